// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single-channel interval timer that counts down on a one-microsecond tick strobe supplied from outside. Software arms it through a trigger register that carries an enable flag, a periodic-mode flag and a reload value. The reload value is the wanted interval in ticks minus one. When the count is already zero and one more tick arrives, the timer expires and latches a pending interrupt. The interrupt output is a level and is active high.

In one-shot mode an expiry turns the timer off and the count stays at zero. In periodic mode the count is reloaded on the expiring tick and the timer keeps running, so it fires every reload+1 ticks. A second register reads back the live count and the pending flag, and software acknowledges the interrupt by writing that register.

The register interface is a simple synchronous write strobe with a combinational read path. Tick generation, interrupt routing and the software event layer sit outside the block.

Top module: `ivtmr_top`

## Requirements
- R1: After reset the enable, periodic flag, reload value, count and pending flag are all zero, `irq` is low, and both registers read 0.
- R2: A write to the trigger register (byte offset 0x0) stores bit 31 as enable, bit 30 as periodic mode and bits 28:0 as the reload value. A read of offset 0x0 returns those fields in the same positions with every other bit 0. The written bit 29 is discarded.
- R3: While the timer is enabled, each cycle with `tick` high and a nonzero count lowers the count by one. With `tick` low, or with the timer disabled, the count holds.
- R4: A tick that arrives while the timer is enabled and the count is zero is an expiry and sets the pending flag. The interval from arming to the first expiry is therefore reload+1 ticks, for example 10 000 ticks for a reload of 9999.
- R5: When an expiry happens in one-shot mode (bit 30 = 0), the enable flag clears and the count stays at zero.
- R6: When an expiry happens in periodic mode (bit 30 = 1), the count reloads from the reload value on the same tick and the timer stays enabled.
- R7: A read of the status register (byte offset 0x4) returns the live count in bits 28:0 and the pending flag in bit 30, with all other bits 0. A write to 0x4 with bit 30 = 1 clears the pending flag, and a write with bit 30 = 0 has no effect.
- R8: When an expiry and a clear write fall in the same cycle, the pending flag stays set.
- R9: `irq` is high exactly while the pending flag is set. It stays high until it is cleared, even across further reloads.
- R10: A write of zero to the trigger register stops the timer and the count reads 0.
- R11: Any trigger write restarts the countdown from the new reload value, even while the timer is running and even when a tick falls in the same cycle as the write. The tick in that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe (1 MHz rate) |
| reg_addr | input | 3 | Register byte offset (0x0 trigger, 0x4 status) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level, active-high interrupt |

## Verification
Every register write and every tick takes effect at the clock edge that samples it. The count, flags and `irq` change at that edge, and `reg_rdata` follows combinationally from the new state. The bench therefore drives inputs at the falling edge and reads the result at the following falling edge, one full edge later, with no extra delay assumed. An expiry is due on the tick numbered reload+1 after arming. The bench checks the cycle just before that tick, where nothing is pending yet, and the cycle just after it, where the flag is set. Same-cycle collisions (clear against expiry, trigger write against tick) are driven in one cycle so that the priority shows on the next read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register selected by an access
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TRIG = 2'd1,
    SEL_STAT = 2'd2
  } tmr_sel_e;

  localparam int TMR_DATA_W  = 32;
  localparam int TMR_CNT_W   = 29;
  localparam int TMR_EN_BIT  = 31;
  localparam int TMR_PER_BIT = 30;
  localparam int TMR_ACK_BIT = 30;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W   = TMR_DATA_W,
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = TMR_CNT_W,
  parameter int EN_BIT   = TMR_EN_BIT,
  parameter int PER_BIT  = TMR_PER_BIT,
  parameter int ACK_BIT  = TMR_ACK_BIT,
  parameter int TRIG_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cur_en,
  input  logic              cur_per,
  input  logic [CNT_W-1:0]  cur_reload,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic              cur_pend,
  output logic              trig_wr,
  output logic              new_en,
  output logic              new_per,
  output logic [CNT_W-1:0]  new_reload,
  output logic              clr_req,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  function automatic tmr_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == TRIG_A)      return SEL_TRIG;
    else if (a == STAT_A) return SEL_STAT;
    else                  return SEL_NONE;
  endfunction

  tmr_sel_e sel;

  always_comb begin
    sel        = decode(addr);
    trig_wr    = wr && (sel == SEL_TRIG);
    clr_req    = wr && (sel == SEL_STAT) && wdata[ACK_BIT];
    new_en     = wdata[EN_BIT];
    new_per    = wdata[PER_BIT];
    new_reload = wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_TRIG: begin
        rdata[CNT_W-1:0] = cur_reload;
        rdata[EN_BIT]    = cur_en;
        rdata[PER_BIT]   = cur_per;
      end
      SEL_STAT: begin
        rdata[CNT_W-1:0] = cur_cnt;
        rdata[ACK_BIT]   = cur_pend;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig_wr,
  input  logic             new_en,
  input  logic             new_per,
  input  logic [CNT_W-1:0] new_reload,
  output logic             en_q,
  output logic             per_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_evt
);
  // count value after one enabled tick
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] rl, input logic per);
    if (c != '0) return c - 1'b1;
    else if (per) return rl;
    else          return '0;
  endfunction

  logic run_tick;
  assign run_tick   = en_q && tick && !trig_wr;
  assign expire_evt = run_tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (trig_wr) begin
      en_q     <= new_en;
      per_q    <= new_per;
      reload_q <= new_reload;
      cnt_q    <= new_reload;
    end else if (run_tick) begin
      cnt_q <= step_count(cnt_q, reload_q, per_q);
      if (expire_evt && !per_q) en_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  input  logic clr_req,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (expire_evt) pend_q <= 1'b1;
    else if (clr_req)    pend_q <= 1'b0;
  end
endmodule

// File: rtl/ivtmr_top.sv
module ivtmr_top
  import tmr_pkg::*;
#(
  parameter int DATA_W   = TMR_DATA_W,
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = TMR_CNT_W,
  parameter int EN_BIT   = TMR_EN_BIT,
  parameter int PER_BIT  = TMR_PER_BIT,
  parameter int ACK_BIT  = TMR_ACK_BIT,
  parameter int TRIG_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             trig_wr, new_en, new_per, clr_req;
  logic [CNT_W-1:0] new_reload;
  logic             en_q, per_q, pend_q, expire_evt;
  logic [CNT_W-1:0] reload_q, cnt_q;

  tmr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
    .PER_BIT(PER_BIT), .ACK_BIT(ACK_BIT), .TRIG_OFS(TRIG_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .cur_en(en_q), .cur_per(per_q), .cur_reload(reload_q), .cur_cnt(cnt_q),
    .cur_pend(pend_q), .trig_wr(trig_wr), .new_en(new_en), .new_per(new_per),
    .new_reload(new_reload), .clr_req(clr_req), .rdata(reg_rdata)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_wr(trig_wr),
    .new_en(new_en), .new_per(new_per), .new_reload(new_reload),
    .en_q(en_q), .per_q(per_q), .reload_q(reload_q), .cnt_q(cnt_q),
    .expire_evt(expire_evt)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt), .clr_req(clr_req),
    .pend_q(pend_q)
  );

  assign irq = pend_q;
endmodule

// File: rtl/ivtmr_chk.sv
module ivtmr_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             trig_wr,
  input logic             clr_req,
  input logic             en_q,
  input logic             per_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expire_evt,
  input logic             irq
);
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !trig_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en_q || !tick) && !trig_wr) |=> $stable(cnt_q));
  // R4
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> irq);
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !per_q) |=> (!en_q && cnt_q == '0));
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && per_q) |=> (en_q && cnt_q == $past(reload_q)));
  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire_evt) |=> !irq);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);
  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> (cnt_q == reload_q));
endmodule

bind ivtmr_top ivtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .trig_wr(trig_wr), .clr_req(clr_req),
  .en_q(en_q), .per_q(per_q), .reload_q(reload_q), .cnt_q(cnt_q),
  .expire_evt(expire_evt), .irq(irq)
);

// File: tb/ivtmr_top_tb_top.sv
`timescale 1ns/1ps
module ivtmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ivtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [2:0]  A_TRIG = 3'h0;
  localparam logic [2:0]  A_STAT = 3'h4;
  localparam logic [31:0] ACK    = 32'h4000_0000;

  // vector table: reload, periodic, ticks, expected count, pending, enable
  localparam int NV = 9;
  localparam int VR [NV] = '{5, 5, 5, 4, 4, 0, 0, 0, 2};
  localparam int VP [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 1};
  localparam int VN [NV] = '{3, 6, 9, 5, 7, 3, 0, 1, 0};
  localparam int VC [NV] = '{2, 0, 0, 4, 2, 0, 0, 0, 2};
  localparam int VI [NV] = '{0, 1, 1, 1, 1, 1, 0, 1, 0};
  localparam int VE [NV] = '{1, 0, 0, 1, 1, 1, 1, 0, 1};

  function automatic logic [31:0] trig_word(input int en, input int per, input int rl);
    return {en[0], per[0], 1'b0, rl[28:0]};
  endfunction

  function automatic logic [31:0] stat_word(input int pend, input int cnt);
    return {1'b0, pend[0], 1'b0, cnt[28:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, the rising edge samples it
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic tk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk;
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, A_TRIG, 32'd0, 1'b1);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(A_TRIG, v); check("R1 trig reset", v, 32'd0);
    rd(A_STAT, v); check("R1 stat reset", v, 32'd0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table walk
    for (int k = 0; k < NV; k++) begin
      cyc(1'b1, A_TRIG, trig_word(1, VP[k], VR[k]), 1'b0);
      cyc(1'b1, A_STAT, ACK, 1'b0);
      ticks(VN[k]);
      rd(A_STAT, v); check($sformatf("R4/R5/R6/R7 vec%0d stat", k), v, stat_word(VI[k], VC[k]));
      rd(A_TRIG, v); check($sformatf("R2/R5 vec%0d trig", k), v, trig_word(VE[k], VP[k], VR[k]));
      check($sformatf("R9 vec%0d irq", k), {31'd0, irq}, {31'd0, VI[k] == 1});
    end

    // R2: bit 29 dropped, largest reload
    cyc(1'b1, A_STAT, ACK, 1'b0);
    cyc(1'b1, A_TRIG, 32'hA000_0005, 1'b0);
    rd(A_TRIG, v); check("R2 bit29 discarded", v, 32'h8000_0005);
    cyc(1'b1, A_TRIG, 32'h9FFF_FFFF, 1'b0);
    rd(A_TRIG, v); check("R2 max reload readback", v, 32'h9FFF_FFFF);
    ticks(1);
    rd(A_STAT, v); check("R3 max reload decrement", v, 32'h1FFF_FFFE);
    // R3: no tick means hold
    cyc(1'b0, A_TRIG, 32'd0, 1'b0); cyc(1'b0, A_TRIG, 32'd0, 1'b0);
    rd(A_STAT, v); check("R3 hold without tick", v, 32'h1FFF_FFFE);

    // R11: restart while running, tick in same cycle is dropped
    cyc(1'b1, A_TRIG, 32'h8000_0005, 1'b0);
    ticks(2);
    rd(A_STAT, v); check("R11 pre-restart count", v, 32'd3);
    cyc(1'b1, A_TRIG, 32'h8000_0008, 1'b1);
    rd(A_STAT, v); check("R11 restart with tick", v, 32'd8);

    // R10: write zero stops; ticks ignored
    cyc(1'b1, A_TRIG, 32'd0, 1'b0);
    rd(A_STAT, v); check("R10 stop count", v, 32'd0);
    ticks(3);
    rd(A_STAT, v); check("R10/R3 disabled ticks ignored", v, 32'd0);
    rd(A_TRIG, v); check("R10 stopped trig", v, 32'd0);

    // R7: write without ack bit keeps pending; R8 collision
    cyc(1'b1, A_TRIG, 32'hC000_0000, 1'b0);
    ticks(1);
    rd(A_STAT, v); check("R4 reload0 expires", v, 32'h4000_0000);
    cyc(1'b1, A_STAT, 32'h1FFF_FFFF, 1'b0);
    rd(A_STAT, v); check("R7 non-ack write no effect", v, 32'h4000_0000);
    cyc(1'b1, A_STAT, ACK, 1'b1);
    check("R8 expiry beats clear", {31'd0, irq}, 32'd1);
    cyc(1'b1, A_STAT, ACK, 1'b0);
    check("R9 irq low after clear", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); check("R7 ack clears pending", v, 32'd0);

    // R4/R6: periodic 10000-tick interval
    cyc(1'b1, A_TRIG, 32'hC000_270F, 1'b0);
    ticks(9999);
    rd(A_STAT, v); check("R4 tick 9999 not pending", v, 32'd0);
    ticks(1);
    rd(A_STAT, v); check("R4/R6 tick 10000 expiry", v, 32'h4000_270F);
    ticks(10000);
    check("R9 irq held across reload", {31'd0, irq}, 32'd1);
    rd(A_STAT, v); check("R6 second period", v, 32'h4000_270F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule